// File: doc/BRIEF.md
# Grouped Pin-Change Interrupt Controller

This peripheral watches a bank of general-purpose input pins, organised as three groups of up to eight pins, and raises one interrupt request per group whenever a selected pin in that group changes level in either direction. Every pin is synchronised to the peripheral clock with two flops before it is compared against its value from the previous cycle. Software picks the pins that count through a mask register for each group. It arms each group through an enable register, and it reads or clears the pending events through a flag register. All of these registers sit on a byte-wide register bus that has an address, a write strobe, write data and combinational read data.

A group's request output is the AND of three things: its pending flag, its enable bit and a global interrupt-enable input. When the processor takes that group's vector, it pulses the group's acknowledge input, and the pending flag clears. Software can also clear a flag by writing a one to it. If a new change event arrives in the same cycle as either kind of clear, the event wins.

Top module: `pinchg_irq`

## Requirements
- R1: Group 0 watches pins 7..0, group 1 watches pins 14..8, and group 2 watches pins 23..16. Pin 15 never sets any flag.
- R2: A change on a pin whose mask bit is zero does not set its group's flag.
- R3: A rising or a falling change on a masked-in pin sets its group's flag, which is bit g of the flag register at address 0x3B. The flag is visible on the third rising clock edge after the pin changes.
- R4: Request output g is high exactly when flag g, enable bit g of the control register at address 0x68, and the global enable input are all high.
- R5: A one-cycle pulse on acknowledge input g clears flag g.
- R6: Writing a one to a flag bit clears that bit. Writing a zero leaves it unchanged.
- R7: Bits 7..3 of the control register and of the flag register read as zero and ignore writes. Control bits 2..0 can be read and written.
- R8: After reset, the enable bits, the flag bits and all three mask registers read zero, and every request output is low.
- R9: The mask registers for groups 0, 1 and 2 are at addresses 0x6B, 0x6C and 0x6D. Bit 7 of the group 1 mask always reads zero.
- R10: When a change event and a clear (acknowledge or write-one) occur in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pins_i | input | 24 | Asynchronous input pins; bit 15 is not connected to any group |
| addr_i | input | 8 | Register bus address |
| wr_i | input | 1 | Register write strobe |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data for addr_i |
| gie_i | input | 1 | Global interrupt enable |
| ack_i | input | 3 | Per-group vector acknowledge pulse |
| irq_o | output | 3 | Per-group interrupt request |

## Verification
The hardest case to reach from the ports is a change event that arrives in the very cycle an acknowledge clears the same flag. The event only exists internally, two clock edges after the pin moves. The stimulus first sets the group 2 flag. It then toggles pin 16 on a falling edge and raises the acknowledge for exactly the one cycle that follows the second rising edge, so the clear lands on the detection cycle. It then reads the flag register to confirm the event survived.

// File: rtl/pinchg_pkg.sv
package pinchg_pkg;
  localparam int BYTE_W = 8;

  // next value of a pending flag: a fresh event beats any clear
  function automatic logic flag_next(logic cur, logic set, logic clr);
    return set | (cur & ~clr);
  endfunction

  // true when any selected pin saw a change
  function automatic logic any_selected(logic [BYTE_W-1:0] chg, logic [BYTE_W-1:0] sel);
    return |(chg & sel);
  endfunction
endpackage

// File: rtl/pinchg_sync.sv
module pinchg_sync #(
  parameter int W = 24
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] chg_o
);
  logic [W-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign chg_o = sync_q ^ prev_q;
endmodule

// File: rtl/pinchg_group.sv
module pinchg_group
  import pinchg_pkg::*;
#(
  parameter int               GW    = 8,
  parameter logic [GW-1:0]    VALID = '1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [GW-1:0] chg_i,
  input  logic          mask_we_i,
  input  logic [GW-1:0] wdata_i,
  input  logic          clr_i,
  input  logic          ack_i,
  input  logic          en_i,
  input  logic          gie_i,
  output logic [GW-1:0] mask_o,
  output logic          hit_o,
  output logic          flag_o,
  output logic          irq_o
);
  logic [GW-1:0] mask_q;
  logic          flag_q;
  logic [BYTE_W-1:0] chg_w, mask_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mask_q <= '0;
    else if (mask_we_i) mask_q <= wdata_i & VALID;
  end

  assign chg_w  = BYTE_W'(chg_i);
  assign mask_w = BYTE_W'(mask_q);
  assign hit_o  = any_selected(chg_w, mask_w);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= flag_next(flag_q, hit_o, clr_i | ack_i);
  end

  assign mask_o = mask_q;
  assign flag_o = flag_q;
  assign irq_o  = flag_q & en_i & gie_i;
endmodule

// File: rtl/pinchg_irq.sv
module pinchg_irq #(
  parameter int                NGRP       = 3,
  parameter int                GW         = 8,
  parameter int                AW         = 8,
  parameter logic [NGRP*GW-1:0] VALID_MASK = 24'hFF7FFF,
  parameter logic [AW-1:0]     ADDR_CTRL  = 8'h68,
  parameter logic [AW-1:0]     ADDR_FLAG  = 8'h3B,
  parameter logic [AW-1:0]     ADDR_MASK0 = 8'h6B
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NGRP*GW-1:0]   pins_i,
  input  logic [AW-1:0]        addr_i,
  input  logic                 wr_i,
  input  logic [7:0]           wdata_i,
  output logic [7:0]           rdata_o,
  input  logic                 gie_i,
  input  logic [NGRP-1:0]      ack_i,
  output logic [NGRP-1:0]      irq_o
);
  localparam int NPIN = NGRP * GW;

  logic [NPIN-1:0]         pin_chg;
  logic [NGRP-1:0]         en_q;
  logic [NGRP-1:0]         flag_clr;
  logic [NGRP-1:0]         grp_hit;
  logic [NGRP-1:0]         grp_flag;
  logic [NGRP-1:0][GW-1:0] grp_mask;

  pinchg_sync #(.W(NPIN)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pins_i),
    .chg_o (pin_chg)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         en_q <= '0;
    else if (wr_i && addr_i == ADDR_CTRL) en_q <= wdata_i[NGRP-1:0];
  end

  assign flag_clr = (wr_i && addr_i == ADDR_FLAG) ? wdata_i[NGRP-1:0] : '0;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam logic [AW-1:0] MADDR = ADDR_MASK0 + AW'(g);
    pinchg_group #(
      .GW   (GW),
      .VALID(VALID_MASK[g*GW +: GW])
    ) u_grp (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .chg_i    (pin_chg[g*GW +: GW]),
      .mask_we_i(wr_i && addr_i == MADDR),
      .wdata_i  (wdata_i[GW-1:0]),
      .clr_i    (flag_clr[g]),
      .ack_i    (ack_i[g]),
      .en_i     (en_q[g]),
      .gie_i    (gie_i),
      .mask_o   (grp_mask[g]),
      .hit_o    (grp_hit[g]),
      .flag_o   (grp_flag[g]),
      .irq_o    (irq_o[g])
    );
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_CTRL)      rdata_o[NGRP-1:0] = en_q;
    else if (addr_i == ADDR_FLAG) rdata_o[NGRP-1:0] = grp_flag;
    for (int g = 0; g < NGRP; g++) begin
      if (addr_i == ADDR_MASK0 + AW'(g)) rdata_o[GW-1:0] = grp_mask[g];
    end
  end
endmodule

// File: rtl/pinchg_chk.sv
module pinchg_chk #(
  parameter int            NGRP      = 3,
  parameter int            AW        = 8,
  parameter logic [AW-1:0] ADDR_CTRL = 8'h68,
  parameter logic [AW-1:0] ADDR_FLAG = 8'h3B
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            gie_i,
  input logic [NGRP-1:0] ack_i,
  input logic [NGRP-1:0] irq_o,
  input logic [AW-1:0]   addr_i,
  input logic [7:0]      rdata_o,
  input logic [NGRP-1:0] grp_hit,
  input logic [NGRP-1:0] grp_flag
);
  for (genvar g = 0; g < NGRP; g++) begin : g_chk
    // R4
    irq_needs_gie_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[g] |-> gie_i);
    // R4
    irq_needs_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[g] |-> grp_flag[g]);
    // R10
    set_beats_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      grp_hit[g] |=> grp_flag[g]);
    // R5
    ack_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_i[g] && !grp_hit[g]) |=> !grp_flag[g]);
    // R2
    flag_rise_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(grp_flag[g]) |-> $past(grp_hit[g]));
  end

  always_comb begin
    if (rst_ni && (addr_i == ADDR_CTRL || addr_i == ADDR_FLAG)) begin
      // R7
      reserved_zero_chk: assert (rdata_o[7:NGRP] == '0);
    end
  end
endmodule

bind pinchg_irq pinchg_chk #(
  .NGRP     (NGRP),
  .AW       (AW),
  .ADDR_CTRL(ADDR_CTRL),
  .ADDR_FLAG(ADDR_FLAG)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .gie_i   (gie_i),
  .ack_i   (ack_i),
  .irq_o   (irq_o),
  .addr_i  (addr_i),
  .rdata_o (rdata_o),
  .grp_hit (grp_hit),
  .grp_flag(grp_flag)
);

// File: tb/test_pinchg_irq.sv
module test_pinchg_irq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] pins = '0;
  logic [7:0]  addr = '0;
  logic        wr = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        gie = 1'b0;
  logic [2:0]  ack = '0;
  logic [2:0]  irq;
  int          nchk = 0;
  int          nfail = 0;
  logic [7:0]  rv;

  localparam logic [7:0] A_CTRL = 8'h68;
  localparam logic [7:0] A_FLAG = 8'h3B;
  localparam logic [7:0] A_M0   = 8'h6B;
  localparam logic [7:0] A_M1   = 8'h6C;
  localparam logic [7:0] A_M2   = 8'h6D;

  always #2.5 clk = ~clk;

  pinchg_irq i_pinchg_irq (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .pins_i (pins),
    .addr_i (addr),
    .wr_i   (wr),
    .wdata_i(wdata),
    .rdata_o(rdata),
    .gie_i  (gie),
    .ack_i  (ack),
    .irq_o  (irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  // flip one pin, then wait until the flag is visible (three rising edges)
  task automatic toggle(input int idx);
    @(negedge clk);
    pins[idx] = ~pins[idx];
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset;
    rd_reg(A_CTRL, rv); chk("R8 ctrl", rv, 8'h00);
    rd_reg(A_FLAG, rv); chk("R8 flag", rv, 8'h00);
    rd_reg(A_M0, rv);   chk("R8 mask0", rv, 8'h00);
    rd_reg(A_M1, rv);   chk("R8 mask1", rv, 8'h00);
    rd_reg(A_M2, rv);   chk("R8 mask2", rv, 8'h00);
    chk("R8 irq", {5'b0, irq}, 8'h00);
  endtask

  task automatic t_regs;
    wr_reg(A_M0, 8'hFF); wr_reg(A_M1, 8'hFF); wr_reg(A_M2, 8'hFF);
    rd_reg(A_M0, rv); chk("R9 mask0", rv, 8'hFF);
    rd_reg(A_M1, rv); chk("R9 mask1 bit7", rv, 8'h7F);
    rd_reg(A_M2, rv); chk("R9 mask2", rv, 8'hFF);
    wr_reg(A_CTRL, 8'hFF);
    rd_reg(A_CTRL, rv); chk("R7 ctrl reserved", rv, 8'h07);
    wr_reg(A_CTRL, 8'h00);
    rd_reg(A_CTRL, rv); chk("R7 ctrl rw", rv, 8'h00);
  endtask

  task automatic t_edges;
    wr_reg(A_M0, 8'h01);
    toggle(0);
    rd_reg(A_FLAG, rv); chk("R3 rise", rv, 8'h01);
    wr_reg(A_FLAG, 8'hFE);
    rd_reg(A_FLAG, rv); chk("R6 zero keeps", rv, 8'h01);
    wr_reg(A_FLAG, 8'h01);
    rd_reg(A_FLAG, rv); chk("R6 one clears", rv, 8'h00);
    toggle(0);
    rd_reg(A_FLAG, rv); chk("R3 fall", rv, 8'h01);
    wr_reg(A_FLAG, 8'h01);
    toggle(1);
    rd_reg(A_FLAG, rv); chk("R2 unmasked", rv, 8'h00);
  endtask

  task automatic t_groups;
    wr_reg(A_M0, 8'hFF); wr_reg(A_M1, 8'hFF); wr_reg(A_M2, 8'hFF);
    toggle(10);
    rd_reg(A_FLAG, rv); chk("R1 pin10 grp1", rv, 8'h02);
    wr_reg(A_FLAG, 8'h07);
    toggle(20);
    rd_reg(A_FLAG, rv); chk("R1 pin20 grp2", rv, 8'h04);
    wr_reg(A_FLAG, 8'h07);
    toggle(15);
    rd_reg(A_FLAG, rv); chk("R1 pin15 none", rv, 8'h00);
    toggle(7);
    rd_reg(A_FLAG, rv); chk("R1 pin7 grp0", rv, 8'h01);
    wr_reg(A_FLAG, 8'hFF);
    rd_reg(A_FLAG, rv); chk("R7 flag reserved", rv, 8'h00);
  endtask

  task automatic t_irq_ack;
    wr_reg(A_CTRL, 8'h07);
    toggle(3);
    @(negedge clk); #1 chk("R4 gie low", {5'b0, irq}, 8'h00);
    gie = 1'b1;
    #1 chk("R4 request", {5'b0, irq}, 8'h01);
    wr_reg(A_CTRL, 8'h06);
    #1 chk("R4 enable off", {5'b0, irq}, 8'h00);
    wr_reg(A_CTRL, 8'h07);
    #1 chk("R4 enable on", {5'b0, irq}, 8'h01);
    @(negedge clk); ack = 3'b001;
    @(negedge clk); ack = 3'b000;
    rd_reg(A_FLAG, rv); chk("R5 ack clears", rv, 8'h00);
    #1 chk("R5 irq drops", {5'b0, irq}, 8'h00);
  endtask

  task automatic t_race;
    toggle(16);
    rd_reg(A_FLAG, rv); chk("R10 setup", rv, 8'h04);
    @(negedge clk); pins[16] = ~pins[16];
    @(negedge clk);
    @(negedge clk); ack = 3'b100;
    @(negedge clk); ack = 3'b000;
    rd_reg(A_FLAG, rv); chk("R10 ack race", rv, 8'h04);
    @(negedge clk); pins[17] = ~pins[17];
    @(negedge clk);
    @(negedge clk); addr = A_FLAG; wdata = 8'h04; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
    rd_reg(A_FLAG, rv); chk("R10 write race", rv, 8'h04);
    wr_reg(A_FLAG, 8'h04);
    rd_reg(A_FLAG, rv); chk("R6 final clear", rv, 8'h00);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_edges();
    t_groups();
    t_irq_ack();
    t_race();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule